// File: doc/BRIEF.md
# Control Register Ownership Intercept Unit

This unit decides what a guest sees and what a guest may change when it touches one of three control registers: the two mode-control registers (CR0 and CR4) and the page-table base register. For each mode-control register a per-bit ownership mask splits the bits between host and guest. Host-owned bits read back from a read shadow. A guest write that tries to move a host-owned bit away from its shadow value is trapped. Guest-owned bits read the live register and take the written value directly.

For the page-table base register, a small associative whitelist of target values decides whether a write may proceed without a trap. The whitelist has up to four entries and a count of valid entries. The surrounding core presents a strobe with a register select and, when writing, the data. One cycle later the unit returns the read data, or a trap flag, or an update for the selected register. Recording the trap and any paging side effects is left to other logic.

Top module: `ctlreg_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output is zero.
- R2: A read (rd_i=1, wr_i=0) with sel_i=0 (CR0) or sel_i=1 (CR4) returns one cycle later, with rvalid_o=1, the shadow bit where the mask bit is 1 and the live register bit where the mask bit is 0.
- R3: A read with sel_i=2 (page-table base) returns ptb_i unchanged one cycle later, with rvalid_o=1.
- R4: A write to CR0 or CR4 raises trap_o one cycle later if any bit that is set in the mask differs from the shadow, and then produces no update.
- R5: A write to CR0 or CR4 that does not trap produces upd_valid_o=1, upd_sel_o equal to the select, and an update value taken from the write data in unmasked bits and from the live register in masked bits.
- R6: A write to the page-table base that equals a valid target value does not trap, and updates that register with the write data.
- R7: A target count of 0 makes every page-table base write trap. A count above 4 behaves as 4.
- R8: Target entries whose index is not below the effective count never suppress a trap.
- R9: When rd_i and wr_i are both set, only the write is processed. With sel_i=3 a strobe has no effect, and all outputs stay zero.
- R10: Results appear exactly one cycle after the strobe and last one cycle. Outputs not carrying a result are zero. trap_o and upd_valid_o are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select: 0 CR0, 1 CR4, 2 page-table base, 3 none |
| rd_i | input | 1 | Guest read strobe |
| wr_i | input | 1 | Guest write strobe |
| wdata_i | input | XLEN | Guest write data |
| cr0_i | input | XLEN | Live CR0 value |
| cr4_i | input | XLEN | Live CR4 value |
| ptb_i | input | XLEN | Live page-table base value |
| cr0_mask_i | input | XLEN | CR0 ownership mask, 1 = host-owned |
| cr0_shadow_i | input | XLEN | CR0 read shadow |
| cr4_mask_i | input | XLEN | CR4 ownership mask, 1 = host-owned |
| cr4_shadow_i | input | XLEN | CR4 read shadow |
| tgt_val_i | input | NUM_TGT*XLEN | Target values, entry k in bits [k*XLEN +: XLEN] |
| tgt_cnt_i | input | CNT_W | Number of valid target entries |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | XLEN | Read result |
| trap_o | output | 1 | Write trapped |
| upd_valid_o | output | 1 | Register update valid |
| upd_sel_o | output | 2 | Register to update |
| upd_val_o | output | XLEN | New register value |

## Verification
The bench uses the default parameters: XLEN=64, NUM_TGT=4 and CNT_W=3. A three-bit count lets the bench drive counts 5 to 7, which reaches the saturation case. With four entries, a match on the last entry flips between trapped and allowed as the count moves from 3 to 4. Full 64-bit masks let the bench place host-owned bits at both ends of the word.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR4  = 2'd1,
    SEL_PTB  = 2'd2,
    SEL_NONE = 2'd3
  } crsel_e;
endpackage

// File: rtl/ctlreg_mask_unit.sv
module ctlreg_mask_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] shadow_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            trap_o,
  output logic [XLEN-1:0] upd_o
);
  assign rdata_o = (mask_i & shadow_i) | (~mask_i & cur_i);
  assign trap_o  = |((wdata_i ^ shadow_i) & mask_i);
  // host-owned bits keep the live value
  assign upd_o   = (wdata_i & ~mask_i) | (cur_i & mask_i);

  // R5
  host_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !trap_o) |-> ((upd_o & mask_i) == (cur_i & mask_i)));
  // R2
  guest_bits_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & ~mask_i) == (cur_i & ~mask_i)));
endmodule

// File: rtl/ctlreg_tgt_match.sv
module ctlreg_tgt_match #(
  parameter int XLEN    = 64,
  parameter int NUM_TGT = 4,
  parameter int CNT_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [XLEN-1:0]         wdata_i,
  input  logic [NUM_TGT*XLEN-1:0] tgt_val_i,
  input  logic [CNT_W-1:0]        tgt_cnt_i,
  output logic                    hit_o
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(NUM_TGT);

  logic [CNT_W-1:0]   eff_cnt;
  logic [NUM_TGT-1:0] ent_hit;

  assign eff_cnt = (tgt_cnt_i > MaxCnt) ? MaxCnt : tgt_cnt_i;

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_ent
    assign ent_hit[k] = (CNT_W'(k) < eff_cnt) &&
                        (tgt_val_i[k*XLEN +: XLEN] == wdata_i);
  end

  assign hit_o = |ent_hit;

  // R7
  zero_cnt_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_cnt_i == '0) |-> !hit_o);
  // R8
  first_entry_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tgt_cnt_i != '0) && (tgt_val_i[XLEN-1:0] == wdata_i)) |-> hit_o);
endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
  import ctlreg_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_TGT = 4,
  parameter int CNT_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              sel_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [XLEN-1:0]         wdata_i,
  input  logic [XLEN-1:0]         cr0_i,
  input  logic [XLEN-1:0]         cr4_i,
  input  logic [XLEN-1:0]         ptb_i,
  input  logic [XLEN-1:0]         cr0_mask_i,
  input  logic [XLEN-1:0]         cr0_shadow_i,
  input  logic [XLEN-1:0]         cr4_mask_i,
  input  logic [XLEN-1:0]         cr4_shadow_i,
  input  logic [NUM_TGT*XLEN-1:0] tgt_val_i,
  input  logic [CNT_W-1:0]        tgt_cnt_i,
  output logic                    rvalid_o,
  output logic [XLEN-1:0]         rdata_o,
  output logic                    trap_o,
  output logic                    upd_valid_o,
  output logic [1:0]              upd_sel_o,
  output logic [XLEN-1:0]         upd_val_o
);
  localparam int NumMasked = 2;

  crsel_e sel;
  assign sel = crsel_e'(sel_i);

  logic [NumMasked-1:0][XLEN-1:0] m_cur, m_mask, m_shadow, m_rdata, m_upd;
  logic [NumMasked-1:0]           m_trap;

  assign m_cur    = {cr4_i, cr0_i};
  assign m_mask   = {cr4_mask_i, cr0_mask_i};
  assign m_shadow = {cr4_shadow_i, cr0_shadow_i};

  for (genvar g = 0; g < NumMasked; g++) begin : g_msk
    ctlreg_mask_unit #(.XLEN(XLEN)) u_msk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_i && (sel_i == 2'(g))),
      .wdata_i  (wdata_i),
      .cur_i    (m_cur[g]),
      .mask_i   (m_mask[g]),
      .shadow_i (m_shadow[g]),
      .rdata_o  (m_rdata[g]),
      .trap_o   (m_trap[g]),
      .upd_o    (m_upd[g])
    );
  end

  logic tgt_hit;
  ctlreg_tgt_match #(.XLEN(XLEN), .NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) u_tgt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .tgt_val_i (tgt_val_i),
    .tgt_cnt_i (tgt_cnt_i),
    .hit_o     (tgt_hit)
  );

  logic            rvalid_d, trap_d, updv_d;
  logic [XLEN-1:0] rdata_d, updval_d;
  logic [1:0]      updsel_d;

  always_comb begin
    rvalid_d = 1'b0;
    rdata_d  = '0;
    trap_d   = 1'b0;
    updv_d   = 1'b0;
    updsel_d = '0;
    updval_d = '0;
    if (sel != SEL_NONE) begin
      if (wr_i) begin
        // write wins over a simultaneous read
        if (sel == SEL_PTB) begin
          trap_d   = !tgt_hit;
          updv_d   = tgt_hit;
          updval_d = tgt_hit ? wdata_i : '0;
        end else begin
          trap_d   = m_trap[sel[0]];
          updv_d   = !m_trap[sel[0]];
          updval_d = m_trap[sel[0]] ? '0 : m_upd[sel[0]];
        end
        updsel_d = updv_d ? sel_i : 2'd0;
      end else if (rd_i) begin
        rvalid_d = 1'b1;
        rdata_d  = (sel == SEL_PTB) ? ptb_i : m_rdata[sel[0]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      trap_o      <= 1'b0;
      upd_valid_o <= 1'b0;
      upd_sel_o   <= '0;
      upd_val_o   <= '0;
    end else begin
      rvalid_o    <= rvalid_d;
      rdata_o     <= rdata_d;
      trap_o      <= trap_d;
      upd_valid_o <= updv_d;
      upd_sel_o   <= updsel_d;
      upd_val_o   <= updval_d;
    end
  end

  // R10
  trap_upd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && upd_valid_o));
  // R9
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(rd_i && !wr_i && (sel_i != 2'd3)));
  // R10
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o || upd_valid_o) |-> $past(wr_i && (sel_i != 2'd3)));
  // R6
  ptb_upd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && (upd_sel_o == 2'd2)) |-> (upd_val_o == $past(wdata_i)));
endmodule

// File: tb/ctlreg_guard_tb.sv
module ctlreg_guard_tb;
  localparam int XLEN = 64;
  localparam int NT   = 4;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]         sel = 2'd3;
  logic               rd = 1'b0, wr = 1'b0;
  logic [XLEN-1:0]    wdata = '0, cr0 = '0, cr4 = '0, ptb = '0;
  logic [XLEN-1:0]    cr0_m = '0, cr0_s = '0, cr4_m = '0, cr4_s = '0;
  logic [NT*XLEN-1:0] tgt = '0;
  logic [CW-1:0]      cnt = '0;

  logic            rvalid, trap, updv;
  logic [XLEN-1:0] rdata, updval;
  logic [1:0]      updsel;

  ctlreg_guard #(.XLEN(XLEN), .NUM_TGT(NT), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .cr0_i(cr0), .cr4_i(cr4), .ptb_i(ptb),
    .cr0_mask_i(cr0_m), .cr0_shadow_i(cr0_s), .cr4_mask_i(cr4_m),
    .cr4_shadow_i(cr4_s), .tgt_val_i(tgt), .tgt_cnt_i(cnt),
    .rvalid_o(rvalid), .rdata_o(rdata), .trap_o(trap),
    .upd_valid_o(updv), .upd_sel_o(updsel), .upd_val_o(updval)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic            e_rv, e_tr, e_uv;
  logic [XLEN-1:0] e_rd, e_uval;
  logic [1:0]      e_us;

  function automatic logic [XLEN-1:0] shadow_read(input logic [XLEN-1:0] c, m, s);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = m[i] ? s[i] : c[i];
    return r;
  endfunction

  function automatic bit target_ok(input logic [XLEN-1:0] d);
    int n = (int'(cnt) > NT) ? NT : int'(cnt);
    for (int k = 0; k < n; k++) if (tgt[k*XLEN +: XLEN] == d) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model();
    logic [XLEN-1:0] c, m, s;
    bit t;
    e_rv = 0; e_rd = '0; e_tr = 0; e_uv = 0; e_us = '0; e_uval = '0;
    if (sel == 2'd3) return;
    c = (sel == 2'd0) ? cr0 : cr4;
    m = (sel == 2'd0) ? cr0_m : cr4_m;
    s = (sel == 2'd0) ? cr0_s : cr4_s;
    if (wr) begin
      if (sel == 2'd2) t = !target_ok(wdata);
      else begin
        t = 0;
        for (int i = 0; i < XLEN; i++) if (m[i] && wdata[i] != s[i]) t = 1;
      end
      e_tr = t;
      if (!t) begin
        e_uv = 1; e_us = sel;
        e_uval = (sel == 2'd2) ? wdata : shadow_read(wdata, m, c);
      end
    end else if (rd) begin
      e_rv = 1;
      e_rd = (sel == 2'd2) ? ptb : shadow_read(c, m, s);
    end
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (rvalid !== e_rv || rdata !== e_rd || trap !== e_tr || updv !== e_uv ||
        updsel !== e_us || updval !== e_uval) begin
      n_fail++;
      $display("FAIL %s: got rv=%b rd=%h tr=%b uv=%b us=%0d uval=%h exp rv=%b rd=%h tr=%b uv=%b us=%0d uval=%h",
               tag, rvalid, rdata, trap, updv, updsel, updval,
               e_rv, e_rd, e_tr, e_uv, e_us, e_uval);
    end
  endtask

  // drive at negedge, sample one full cycle later at negedge
  task automatic step(input string tag, input logic [1:0] s, input logic r, w,
                      input logic [XLEN-1:0] d);
    sel = s; rd = r; wr = w; wdata = d;
    model();
    @(negedge clk);
    compare(tag);
    sel = 2'd3; rd = 0; wr = 0;
    model();
    @(negedge clk);
    compare({tag, " pulse"});  // R10 single-cycle result
  endtask

  function automatic logic [XLEN-1:0] pick(input int unsigned x);
    case (x % 4)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0011;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    @(negedge clk);
    e_rv = 0; e_rd = '0; e_tr = 0; e_uv = 0; e_us = '0; e_uval = '0;
    compare("R1 in reset");
    rd = 1; wr = 0; sel = 2'd0; cr0 = 64'hABCD;
    @(negedge clk);
    compare("R1 reset holds");
    rst_n = 1; rd = 0; sel = 2'd3;
    @(negedge clk);
    compare("R1 after release");

    cr0 = 64'h1234_5678_9ABC_DEF0; cr0_s = 64'hFFFF_0000_FFFF_0000;
    cr0_m = '0;                         step("R2 cr0 mask none", 2'd0, 1, 0, '0);
    cr0_m = '1;                         step("R2 cr0 mask all", 2'd0, 1, 0, '0);
    cr0_m = 64'h8000_0000_0000_0001;    step("R2 cr0 mask ends", 2'd0, 1, 0, '0);
    cr4 = 64'h0000_0000_0000_06F0; cr4_m = 64'h0000_0000_0000_00F0;
    cr4_s = 64'h0000_0000_0000_0030;    step("R2 cr4 read", 2'd1, 1, 0, '0);
    ptb = 64'hDEAD_BEEF_0000_1000;      step("R3 ptb read", 2'd2, 1, 0, '0);

    step("R4 cr4 host bit changed", 2'd1, 0, 1, 64'h0000_0000_0000_0070);
    step("R4 cr0 top bit changed", 2'd0, 0, 1, 64'h0);
    step("R5 cr4 guest bits only", 2'd1, 0, 1, 64'h1234_0000_0000_0F3F);
    step("R5 cr0 matches shadow", 2'd0, 0, 1, 64'h8000_0000_0000_0000);

    tgt = {64'h4000, 64'h3000, 64'h2000, 64'h1000};
    cnt = 3'd2; step("R6 ptb hit entry1", 2'd2, 0, 1, 64'h2000);
    step("R6 ptb miss", 2'd2, 0, 1, 64'h5000);
    cnt = 3'd0; step("R7 count zero", 2'd2, 0, 1, 64'h1000);
    cnt = 3'd7; step("R7 count saturates", 2'd2, 0, 1, 64'h4000);
    cnt = 3'd5; step("R7 count five", 2'd2, 0, 1, 64'h4000);
    cnt = 3'd3; step("R8 entry3 excluded", 2'd2, 0, 1, 64'h4000);
    cnt = 3'd4; step("R8 entry3 included", 2'd2, 0, 1, 64'h4000);
    cnt = 3'd1; step("R8 entry1 excluded", 2'd2, 0, 1, 64'h2000);

    step("R9 rd and wr together", 2'd1, 1, 1, 64'h0000_0000_0000_0030);
    step("R9 sel none read", 2'd3, 1, 0, '0);
    step("R9 sel none write", 2'd3, 0, 1, 64'h1000);

    for (int i = 0; i < 400; i++) begin
      cr0 = pick($urandom); cr4 = pick($urandom); ptb = pick($urandom);
      cr0_m = pick($urandom); cr0_s = pick($urandom);
      cr4_m = pick($urandom); cr4_s = pick($urandom);
      for (int k = 0; k < NT; k++) tgt[k*XLEN +: XLEN] = pick($urandom);
      cnt = CW'($urandom);
      step("R10 mixed", 2'($urandom), 1'($urandom), 1'($urandom), pick($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: got no finish, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule